// File: doc/BRIEF.md
# Multi-Source A20 Address Gate

This block drives address line 20 of the system address bus. It is needed for real-mode compatibility with early PCs. When no gate source is enabled, the line is held at 0, so an access just above the 1-Mbyte boundary wraps back to the bottom of memory. When any gate source is enabled, the CPU core's own A20 output passes through to the bus unchanged.

There are three gate sources, combined by a logical OR:

- **Keyboard controller pin.** An external level from the keyboard controller. It is asynchronous, so it passes through a two-flop synchronizer first.
- **Configuration register bit.** A gate bit in an indexed configuration register. Software reaches it by writing an index to one I/O port and then accessing the data through a second port.
- **Fast gate bit.** A bit in the system control port at I/O address 92h. Software can flip it in one write, without the slow round trip through the keyboard controller.

Top module: `a20_gate_ctrl`

## Requirements
- R1: After reset the index register, the configuration register at index 6Fh and the port-92h gate bit all read 0. With the keyboard pin low, the system A20 is 0 for either CPU A20 value.
- R2: When the synchronized keyboard pin, the configuration gate bit and the fast gate bit are all 0, the system A20 is 0 whatever the CPU A20 is.
- R3: The keyboard pin reaches the gate through two flip-flops. A level set before clock edge k is still not in effect after edge k. It is in effect after edge k+1.
- R4: A write to I/O address 0092h loads data bit 1 into the fast gate bit. The new value takes effect on the system A20 after that write's clock edge.
- R5: A read of I/O address 0092h returns the fast gate in bit 1 and 0 in every other bit.
- R6: A write to the index port (0022h) selects a register. With index 6Fh selected, a write to the data port (0023h) loads all 8 bits of the configuration register, and a read returns them. Bit 1 of that register is the configuration gate bit.
- R7: With any index other than 6Fh selected, data-port writes change nothing and data-port reads return 0.
- R8: If any one of the three gate sources is 1, the system A20 equals the CPU A20.
- R9: A read of the index port returns the index last written.
- R10: The CPU A20 reaches the system A20 through logic alone, with no clock edge in the path. Read data is also combinational while the read strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_a20 | input | 1 | A20 output of the CPU core |
| kbc_gate | input | 1 | Asynchronous gate level from the keyboard controller |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe, acted on at the clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0 when no read is decoded |
| sys_a20 | output | 1 | A20 driven onto the system address bus |

## Verification
Each result is due at its own latency:

| Result | Due |
|---|---|
| CPU A20 to system A20 | In the same cycle |
| Read data | In the same cycle |
| Register write | One edge after the write |
| Keyboard pin | Two edges after it changes |

The bench drives every input at the falling edge and counts the rising edges before each check. Combinational results are sampled 1 ns after the stimulus. Register and synchronizer effects are sampled at the falling edge after the edge that is due. The keyboard-pin latency is also checked one edge early, to show that the level has not yet arrived. A sweep over all eight gate-source combinations and both CPU A20 values compares the output against the OR rule computed in the bench.

// File: rtl/a20_pkg.sv
// Package: shared I/O decode constants for the A20 gate block.
// Assumes a 16-bit I/O address space and an 8-bit data path.
package a20_pkg;
    localparam int          ADDR_W     = 16;
    localparam int          DATA_W     = 8;
    localparam logic [15:0] IDX_PORT   = 16'h0022;
    localparam logic [15:0] DAT_PORT   = 16'h0023;
    localparam logic [15:0] FAST_PORT  = 16'h0092;
    localparam logic [7:0]  GATE_INDEX = 8'h6F;
    localparam int          GATE_BIT   = 1;

    typedef struct packed {
        logic cfg_gate;
        logic fast_gate;
    } gate_bits_t;
endpackage

// File: rtl/a20_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2. Reset clears the chain synchronously.
module a20_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int WARM_W = $clog2(STAGES + 1);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

    // Count edges since reset so the latency check waits for a full chain.
    logic [WARM_W-1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)                       warm <= '0;
        else if (warm != WARM_W'(STAGES)) warm <= warm + 1'b1;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            // R3: output equals the input from two edges earlier
            assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (warm == WARM_W'(STAGES)) |-> (q_sync == $past(d_async, 2)));
        end
    endgenerate
endmodule

// File: rtl/a20_regs.sv
// Module: I/O-mapped gate registers.
// An index/data pair reaches the configuration register at index 6Fh.
// A system control port holds the fast gate bit.
// Assumes one I/O access per cycle. Writes act at the clock edge, and
// read data is combinational while io_rd is high.
module a20_regs
    import a20_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output gate_bits_t    gates
);
    logic [DW-1:0] index_q;
    logic [DW-1:0] cfg_q;
    logic          fast_q;

    logic hit_idx, hit_dat, hit_fast, idx_match;
    assign hit_idx   = (io_addr == AW'(IDX_PORT));
    assign hit_dat   = (io_addr == AW'(DAT_PORT));
    assign hit_fast  = (io_addr == AW'(FAST_PORT));
    assign idx_match = (index_q == DW'(GATE_INDEX));

    // Hold the index selected for the data port.
    always_ff @(posedge clk) begin
        if (!rst_n)                 index_q <= '0;
        else if (io_wr && hit_idx)  index_q <= io_wdata;
    end

    // Load the configuration register through the data port when it is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cfg_q <= '0;
        else if (io_wr && hit_dat && idx_match) cfg_q <= io_wdata;
    end

    // Load the fast gate bit from the system control port.
    always_ff @(posedge clk) begin
        if (!rst_n)                 fast_q <= 1'b0;
        else if (io_wr && hit_fast) fast_q <= io_wdata[GATE_BIT];
    end

    // Return read data for the decoded port, or 0 otherwise.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (hit_idx)                     io_rdata = index_q;
            else if (hit_dat && idx_match)   io_rdata = cfg_q;
            else if (hit_fast)               io_rdata[GATE_BIT] = fast_q;
        end
    end

    assign gates.cfg_gate  = cfg_q[GATE_BIT];
    assign gates.fast_gate = fast_q;

    // R4: a write to the control port loads data bit 1 into the fast gate
    assert_fast_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit_fast) |=> (gates.fast_gate == $past(io_wdata[GATE_BIT])));

    // R7: data-port writes with another index leave the register unchanged
    assert_other_index_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit_dat && !idx_match) |=> $stable(cfg_q));

    // R9: the index register changes only on an index-port write
    assert_index_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && hit_idx) |=> $stable(index_q));
endmodule

// File: rtl/a20_combine.sv
// Module: merges the gate sources and masks the CPU A20.
// Assumes every gate input is already synchronous to clk.
// Purely combinational.
module a20_combine
    import a20_pkg::*;
(
    input  logic       cpu_a20,
    input  logic       kbc_gate_s,
    input  gate_bits_t gates,
    output logic       sys_a20
);
    logic enable;

    // Any one source opens the gate; otherwise A20 is forced low.
    always_comb begin
        enable  = kbc_gate_s | gates.cfg_gate | gates.fast_gate;
        sys_a20 = cpu_a20 & enable;
    end
endmodule

// File: rtl/a20_gate_ctrl.sv
// Module: top of the multi-source A20 gate.
// The keyboard-controller level is synchronized first. The software
// gate bits are decoded from I/O accesses. The CPU A20 passes to the
// system bus only while some source enables it.
// Assumes a single clock and a synchronous active-low reset.
module a20_gate_ctrl
    import a20_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_a20,
    input  logic          kbc_gate,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          sys_a20
);
    logic       kbc_gate_s;
    gate_bits_t gates;

    a20_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (kbc_gate),
        .q_sync  (kbc_gate_s)
    );

    a20_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .gates    (gates)
    );

    a20_combine u_comb (
        .cpu_a20    (cpu_a20),
        .kbc_gate_s (kbc_gate_s),
        .gates      (gates),
        .sys_a20    (sys_a20)
    );

    // R2: the system A20 never rises while the CPU A20 is low
    assert_cpu_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_a20 |-> !sys_a20);

    // R8: with the fast gate set, the CPU A20 passes straight through
    assert_fast_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gates.fast_gate |-> (sys_a20 == cpu_a20));

    // R2: with no source enabled, the line is forced low
    assert_forced_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbc_gate_s && !gates.cfg_gate && !gates.fast_gate) |-> !sys_a20);
endmodule

// File: tb/sim_a20_gate_ctrl.sv
// Bench: sweeps all gate-source combinations and checks latencies and register decode.
module sim_a20_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_a20 = 1'b0;
    logic        kbc_gate = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        sys_a20;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    a20_gate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_a20(cpu_a20), .kbc_gate(kbc_gate),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .sys_a20(sys_a20)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        io_read(16'h0092, rd); chk(rd, 8'h00, "R1 port92 reset");
        io_read(16'h0022, rd); chk(rd, 8'h00, "R1 index reset");
        io_write(16'h0022, 8'h6F);
        io_read(16'h0023, rd); chk(rd, 8'h00, "R1 cfg reset");
        cpu_a20 = 1'b1; #1 chk(sys_a20, 1'b0, "R1 a20 low after reset");

        // R9: index readback
        io_write(16'h0022, 8'h5A);
        io_read(16'h0022, rd); chk(rd, 8'h5A, "R9 index readback");

        // R7: other index ignored
        io_write(16'h0022, 8'h10);
        io_write(16'h0023, 8'hFF);
        io_read(16'h0023, rd); chk(rd, 8'h00, "R7 other index reads 0");
        io_write(16'h0022, 8'h6F);
        io_read(16'h0023, rd); chk(rd, 8'h00, "R7 cfg untouched");
        @(negedge clk); cpu_a20 = 1'b1; #1 chk(sys_a20, 1'b0, "R7 a20 still gated");

        // R6: full register readback
        io_write(16'h0023, 8'hA5);
        io_read(16'h0023, rd); chk(rd, 8'hA5, "R6 cfg readback");
        io_write(16'h0023, 8'h00);

        // R4/R5: fast gate write and read
        io_write(16'h0092, 8'hFD);
        io_read(16'h0092, rd); chk(rd, 8'h00, "R5 other bits zero");
        @(negedge clk); io_addr = 16'h0092; io_wdata = 8'h02; io_wr = 1'b1; cpu_a20 = 1'b1;
        #1 chk(sys_a20, 1'b0, "R4 not before edge");
        @(negedge clk); io_wr = 1'b0;
        #1 chk(sys_a20, 1'b1, "R4 after write edge");
        io_read(16'h0092, rd); chk(rd, 8'h02, "R5 gate bit readback");
        io_write(16'h0092, 8'h00);

        // R3: keyboard sync latency
        @(negedge clk); cpu_a20 = 1'b1; kbc_gate = 1'b1;
        @(negedge clk); chk(sys_a20, 1'b0, "R3 one edge early");
        @(negedge clk); chk(sys_a20, 1'b1, "R3 after two edges");
        kbc_gate = 1'b0;
        @(negedge clk); chk(sys_a20, 1'b1, "R3 fall one edge early");
        @(negedge clk); chk(sys_a20, 1'b0, "R3 fall after two edges");

        // R2/R8/R10: exhaustive sweep of sources and CPU A20
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 2; c++) begin
                for (int f = 0; f < 2; f++) begin
                    @(negedge clk); kbc_gate = k[0];
                    io_write(16'h0022, 8'h6F);
                    io_write(16'h0023, {6'b0, c[0], 1'b0});
                    io_write(16'h0092, {6'b0, f[0], 1'b0});
                    repeat (3) @(negedge clk);
                    io_read(16'h0023, rd); chk(rd, {6'b0, c[0], 1'b0}, "R6 sweep cfg");
                    io_read(16'h0092, rd); chk(rd, {6'b0, f[0], 1'b0}, "R5 sweep port92");
                    for (int p = 0; p < 2; p++) begin
                        logic en;
                        en = k[0] | c[0] | f[0];
                        @(negedge clk); cpu_a20 = p[0];
                        #1 chk(sys_a20, p[0] & en, en ? "R8 R10 pass-through" : "R2 forced low");
                    end
                end
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule